// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block manages the packet storage of one bulk or interrupt endpoint on the device side of a USB link. It has two packet buffers that alternate. One side fills a buffer while the other side drains the second. The direction is set by `cfg_dir_in`.

In the IN direction, firmware writes 16-bit words through a register port. A packet closes in one of three ways: it reaches the maximum packet size, it reaches a programmed short length, or firmware sets a validate bit. The USB side then reads the closed packet one byte at a time and releases it. In the OUT direction, the USB side writes received bytes and acknowledges the packet. That loads a byte count, which firmware reads before draining the data one word at a time.

Every firmware access goes through an endpoint index register. A register other than the index register responds only while the index holds this endpoint's number. A status register shows the filled state of each buffer on its own bit.

Top module: `ep_dbuf`

## Requirements
- R1: After `rst_n` is released, the status register reads 0, the length register reads 0, `in_overrun` is 0 and `usb_pkt_avail` is 0.
- R2: While the index register (select 0) differs from `EP_ID` (default 1), reads of selects 1 to 4 return 0 and writes to them have no effect. Index 0 never selects the block.
- R3: In IN mode with the length register at 0, writing `MAX_PKT` bytes as words to the data port (select 1, low byte first) closes the packet. It sets status bit 0, and the next packet fills buffer 1.
- R4: In IN mode, when the length register (select 2) holds a value N with 0 < N < `MAX_PKT`, the packet closes as soon as N bytes have been written.
- R5: When a packet has an odd length, its last data-port write stores only the low byte (bits 7:0). The USB side reads exactly N bytes, and `usb_rdata` is 0 past the end.
- R6: Writing 1 to bit 0 of the control register (select 4) in IN mode closes the current packet with the bytes written so far. This includes a zero-length packet.
- R7: Status (select 3) bit b is 1 exactly when buffer b is filled, and bits 15:2 read 0.
- R8: In IN mode with both buffers filled, a data-port write is refused and leaves both packets unchanged. It sets `in_overrun`, which stays set until a bus reset.
- R9: In IN mode, `usb_pkt_avail` and `usb_pkt_len` describe the oldest filled buffer. `usb_byte_rd` returns its bytes in write order, and `usb_pkt_done` frees that buffer.
- R10: In OUT mode, `usb_pkt_done` closes the bytes received so far into a filled buffer. The length register then reads that byte count for the oldest filled buffer.
- R11: In OUT mode, data-port reads return the oldest packet two bytes per read, low byte in bits 7:0. An odd final byte appears in bits 7:0 with bits 15:8 zero. The read that takes the final byte frees the buffer.
- R12: In OUT mode, `usb_space` is 1 only while the buffer being filled is free. USB bytes and `usb_pkt_done` arriving while both buffers are filled are ignored.
- R13: `bus_rst` empties both buffers and clears the status bits, the length/data-count register and `in_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Synchronous USB bus reset pulse |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| fw_wr | input | 1 | Firmware register write strobe |
| fw_rd | input | 1 | Firmware register read strobe (advances data port) |
| fw_sel | input | 3 | Register select: 0 index, 1 data, 2 length, 3 status, 4 control |
| fw_wdata | input | 16 | Firmware write data |
| fw_rdata | output | 16 | Firmware read data for the selected register |
| usb_byte_wr | input | 1 | OUT: store one received byte |
| usb_wdata | input | 8 | OUT: received byte |
| usb_byte_rd | input | 1 | IN: advance to the next byte to transmit |
| usb_rdata | output | 8 | IN: current byte to transmit |
| usb_pkt_done | input | 1 | IN: packet sent and acknowledged; OUT: packet received and acknowledged |
| usb_pkt_avail | output | 1 | IN: a filled packet is ready |
| usb_pkt_len | output | 16 | IN: length of the ready packet |
| usb_space | output | 1 | OUT: a free buffer can take a packet |
| in_overrun | output | 1 | Sticky flag: a firmware write was refused |

## Verification
The checker assumes that `cfg_dir_in` changes only while `rst_n` or `bus_rst` is asserted. It also assumes that `EP_ID` is nonzero, and that the USB side never sends `usb_pkt_done` for a buffer it has not filled or read. The bench changes direction only inside a bus-reset pulse. It issues USB strobes only in the direction that uses them, except where the refusal cases of R8 and R12 need a stimulus that must have no effect. Each firmware access lasts one cycle, and the index register is written before the accesses that depend on it.

// File: rtl/ep_dbuf_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and field positions for the endpoint buffer.
package ep_dbuf_pkg;
    typedef enum logic [2:0] {
        REG_INDEX  = 3'd0,
        REG_DATA   = 3'd1,
        REG_LENGTH = 3'd2,
        REG_STATUS = 3'd3,
        REG_CTRL   = 3'd4
    } reg_sel_e;

    localparam int CTRL_VALIDATE_BIT = 0;
    localparam int NUM_BUFS          = 2;
endpackage

// File: rtl/ep_dbuf_mem.sv
`timescale 1ns/1ps
// Module: ep_dbuf_mem
// Two packet buffers of DEPTH bytes each. There are two byte write ports, so a
// 16-bit firmware word lands in one cycle, and two combinational byte read ports.
// Assumes: write addresses stay below DEPTH. Callers mask any read beyond the
// packet end.
module ep_dbuf_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wa_en,
    input  logic          wa_buf,
    input  logic [AW-1:0] wa_addr,
    input  logic [7:0]    wa_data,
    input  logic          wb_en,
    input  logic          wb_buf,
    input  logic [AW-1:0] wb_addr,
    input  logic [7:0]    wb_data,
    input  logic          r_buf,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] mem_q [ep_dbuf_pkg::NUM_BUFS][DEPTH];

    // Store the bytes presented on either write lane.
    always_ff @(posedge clk) begin
        if (wa_en) mem_q[wa_buf][wa_addr] <= wa_data;
        if (wb_en) mem_q[wb_buf][wb_addr] <= wb_data;
    end

    // Present both read lanes of the consumer buffer.
    always_comb begin
        ra_data = mem_q[r_buf][ra_addr];
        rb_data = mem_q[r_buf][rb_addr];
    end
endmodule

// File: rtl/ep_dbuf_ring.sv
`timescale 1ns/1ps
// Module: ep_dbuf_ring
// Keeps the state of the two buffers that alternate: a full flag and a byte count
// for each buffer, the producer and consumer pointers, and the byte offsets into
// the buffer being filled and the buffer being drained.
// Assumes: commit only targets a free buffer and release only a full one. Both
// are guaranteed by the top-level qualifiers.
module ep_dbuf_ring #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          release_i,
    input  logic [1:0]    wr_step,
    input  logic [1:0]    rd_step,
    output logic [1:0]    full,
    output logic          prod_ptr,
    output logic          cons_ptr,
    output logic [LW-1:0] wr_idx,
    output logic [LW-1:0] rd_idx,
    output logic [LW-1:0] cons_len
);
    localparam int NB = ep_dbuf_pkg::NUM_BUFS;

    logic [NB-1:0] fill_hit;
    logic [NB-1:0] free_hit;
    logic [LW-1:0] cnt_q [NB];

    // Work out which buffer each commit or release event targets.
    for (genvar b = 0; b < NB; b++) begin : g_hit
        assign fill_hit[b] = commit    && (prod_ptr == 1'(b));
        assign free_hit[b] = release_i && (cons_ptr == 1'(b));
    end

    // Per-buffer full flag and closed-packet byte count.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (!rst_n || clr) begin
                full[b]  <= 1'b0;
                cnt_q[b] <= '0;
            end else if (fill_hit[b]) begin
                full[b]  <= 1'b1;
                cnt_q[b] <= commit_len;
            end else if (free_hit[b]) begin
                full[b]  <= 1'b0;
                cnt_q[b] <= '0;
            end
        end
    end

    // Producer and consumer pointers swap after each commit or release.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_ptr <= 1'b0;
            cons_ptr <= 1'b0;
        end else begin
            if (commit)    prod_ptr <= ~prod_ptr;
            if (release_i) cons_ptr <= ~cons_ptr;
        end
    end

    // Byte offsets into the buffer being filled and the buffer being drained.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            wr_idx <= commit    ? '0 : wr_idx + LW'(wr_step);
            rd_idx <= release_i ? '0 : rd_idx + LW'(rd_step);
        end
    end

    assign cons_len = cnt_q[cons_ptr];
endmodule

// File: rtl/ep_dbuf_regs.sv
`timescale 1ns/1ps
// Module: ep_dbuf_regs
// Firmware register front end. It holds the endpoint index register and the
// programmed short-packet length. It decodes the one-cycle strobes into data
// write, data read and validate events, and it multiplexes the read data.
// Assumes: EP_ID is nonzero, so index 0 (the control endpoint) never matches.
module ep_dbuf_regs #(
    parameter int IDX_W = 4,
    parameter int EP_ID = 1,
    parameter int LW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          dir_in,
    input  logic          fw_wr,
    input  logic          fw_rd,
    input  logic [2:0]    fw_sel,
    input  logic [15:0]   fw_wdata,
    input  logic [1:0]    full,
    input  logic [LW-1:0] cons_len,
    input  logic [15:0]   data_word,
    output logic [15:0]   fw_rdata,
    output logic [LW-1:0] len_q,
    output logic          idx_hit,
    output logic          data_wr,
    output logic          data_rd,
    output logic          validate
);
    import ep_dbuf_pkg::*;

    logic [IDX_W-1:0] idx_q;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(fw_sel);
    assign idx_hit = (idx_q == IDX_W'(EP_ID));

    // Endpoint index register; the bus reset leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idx_q <= '0;
        else if (fw_wr && sel == REG_INDEX)  idx_q <= fw_wdata[IDX_W-1:0];
    end

    // Short-packet length register, writable in IN mode only.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            len_q <= '0;
        else if (fw_wr && idx_hit && dir_in && sel == REG_LENGTH)
            len_q <= LW'(fw_wdata);
    end

    // Decode the data-port and control strobes.
    always_comb begin
        data_wr  = fw_wr && idx_hit && (sel == REG_DATA);
        data_rd  = fw_rd && idx_hit && (sel == REG_DATA);
        validate = fw_wr && idx_hit && (sel == REG_CTRL) && fw_wdata[CTRL_VALIDATE_BIT];
    end

    // Read multiplexer; every register other than the index needs an index hit.
    always_comb begin
        fw_rdata = '0;
        if (sel == REG_INDEX) begin
            fw_rdata = 16'(idx_q);
        end else if (idx_hit) begin
            case (sel)
                REG_DATA:   fw_rdata = data_word;
                REG_LENGTH: fw_rdata = dir_in ? 16'(len_q) : 16'(cons_len);
                REG_STATUS: fw_rdata = {14'd0, full};
                default:    fw_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ep_dbuf.sv
`timescale 1ns/1ps
// Module: ep_dbuf
// Endpoint packet buffer with two buffers that alternate, for one bulk or
// interrupt endpoint. In IN mode, firmware fills packets that close on maximum
// size, on the programmed length or on the validate bit. In OUT mode, the USB
// side fills packets and firmware drains them.
// Assumes: cfg_dir_in changes only while rst_n is low or bus_rst is high.
module ep_dbuf #(
    parameter int MAX_PKT = 64,
    parameter int EP_ID   = 1,
    parameter int IDX_W   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst,
    input  logic        cfg_dir_in,
    input  logic        fw_wr,
    input  logic        fw_rd,
    input  logic [2:0]  fw_sel,
    input  logic [15:0] fw_wdata,
    output logic [15:0] fw_rdata,
    input  logic        usb_byte_wr,
    input  logic [7:0]  usb_wdata,
    input  logic        usb_byte_rd,
    output logic [7:0]  usb_rdata,
    input  logic        usb_pkt_done,
    output logic        usb_pkt_avail,
    output logic [15:0] usb_pkt_len,
    output logic        usb_space,
    output logic        in_overrun
);
    localparam int LW = 16;
    localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
    localparam logic [LW-1:0] MPS = LW'(MAX_PKT);

    logic [1:0]    buf_full;
    logic          prod_ptr, cons_ptr;
    logic [LW-1:0] wr_idx, rd_idx, cons_len, len_q;
    logic          idx_hit, data_wr, data_rd, validate;
    logic [15:0]   data_word;
    logic [7:0]    ra_data, rb_data;

    logic [LW-1:0] tgt, remain, in_add, in_new, commit_len;
    logic          prod_full, cons_full;
    logic          in_wr_ok, in_auto, in_manual, out_wr_ok, out_commit, commit;
    logic          in_rd_ok, out_rd_ok, release_ev, cons_in_range;
    logic [1:0]    wr_step, rd_step;

    assign prod_full = buf_full[prod_ptr];
    assign cons_full = buf_full[cons_ptr];

    // Packet-close target: the programmed short length if valid, else max size.
    always_comb begin
        tgt    = (len_q != '0 && len_q < MPS) ? len_q : MPS;
        remain = tgt - wr_idx;
        in_add = (remain >= LW'(2)) ? LW'(2) : LW'(1);
        in_new = wr_idx + in_add;
    end

    // Producer side: qualify writes and decide when a packet closes.
    always_comb begin
        in_wr_ok   = cfg_dir_in && data_wr && !prod_full && (wr_idx < tgt);
        in_auto    = in_wr_ok && (in_new == tgt);
        in_manual  = cfg_dir_in && validate && !prod_full;
        out_wr_ok  = !cfg_dir_in && usb_byte_wr && !prod_full && (wr_idx < MPS);
        out_commit = !cfg_dir_in && usb_pkt_done && !prod_full;
        commit     = in_auto || in_manual || out_commit;
        commit_len = in_auto ? in_new : wr_idx;
        wr_step    = in_wr_ok ? in_add[1:0] : (out_wr_ok ? 2'd1 : 2'd0);
    end

    // Consumer side: qualify reads and decide when a buffer is freed.
    always_comb begin
        cons_in_range = cons_full && (rd_idx < cons_len);
        in_rd_ok      = cfg_dir_in && usb_byte_rd && cons_in_range;
        out_rd_ok     = !cfg_dir_in && data_rd && cons_full;
        release_ev    = (cfg_dir_in && usb_pkt_done && cons_full) ||
                        (out_rd_ok && (rd_idx + LW'(2) >= cons_len));
        rd_step       = in_rd_ok ? 2'd1 : (out_rd_ok ? 2'd2 : 2'd0);
    end

    // Firmware read word in OUT mode: low byte first, odd tail in the low lane.
    always_comb begin
        data_word = '0;
        if (!cfg_dir_in && cons_in_range) begin
            data_word[7:0]  = ra_data;
            data_word[15:8] = (rd_idx + LW'(1) < cons_len) ? rb_data : 8'd0;
        end
    end

    // Sticky refusal flag for firmware writes into a full pair of buffers.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst)
            in_overrun <= 1'b0;
        else if (cfg_dir_in && data_wr && prod_full)
            in_overrun <= 1'b1;
    end

    assign usb_rdata     = (cfg_dir_in && cons_in_range) ? ra_data : 8'd0;
    assign usb_pkt_avail = cfg_dir_in && cons_full;
    assign usb_pkt_len   = usb_pkt_avail ? cons_len : '0;
    assign usb_space     = !cfg_dir_in && !prod_full;

    ep_dbuf_regs #(.IDX_W(IDX_W), .EP_ID(EP_ID), .LW(LW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bus_rst),
        .dir_in   (cfg_dir_in),
        .fw_wr    (fw_wr),
        .fw_rd    (fw_rd),
        .fw_sel   (fw_sel),
        .fw_wdata (fw_wdata),
        .full     (buf_full),
        .cons_len (cons_len),
        .data_word(data_word),
        .fw_rdata (fw_rdata),
        .len_q    (len_q),
        .idx_hit  (idx_hit),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .validate (validate)
    );

    ep_dbuf_ring #(.LW(LW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bus_rst),
        .commit    (commit),
        .commit_len(commit_len),
        .release_i (release_ev),
        .wr_step   (wr_step),
        .rd_step   (rd_step),
        .full      (buf_full),
        .prod_ptr  (prod_ptr),
        .cons_ptr  (cons_ptr),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .cons_len  (cons_len)
    );

    ep_dbuf_mem #(.DEPTH(MAX_PKT)) u_mem (
        .clk    (clk),
        .wa_en  (in_wr_ok || out_wr_ok),
        .wa_buf (prod_ptr),
        .wa_addr(wr_idx[AW-1:0]),
        .wa_data(cfg_dir_in ? fw_wdata[7:0] : usb_wdata),
        .wb_en  (in_wr_ok && in_add == LW'(2)),
        .wb_buf (prod_ptr),
        .wb_addr(AW'(wr_idx + LW'(1))),
        .wb_data(fw_wdata[15:8]),
        .r_buf  (cons_ptr),
        .ra_addr(rd_idx[AW-1:0]),
        .ra_data(ra_data),
        .rb_addr(AW'(rd_idx + LW'(1))),
        .rb_data(rb_data)
    );
endmodule

// File: rtl/ep_dbuf_chk.sv
`timescale 1ns/1ps
// Module: ep_dbuf_chk
// Property checker for ep_dbuf, attached through bind. It watches the ports and
// the buffer full flags.
// Assumes: direction changes only during a reset or a bus reset.
module ep_dbuf_chk #(
    parameter int MAX_PKT = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rst,
    input logic        cfg_dir_in,
    input logic        fw_wr,
    input logic        fw_rd,
    input logic [2:0]  fw_sel,
    input logic [15:0] fw_rdata,
    input logic        usb_pkt_done,
    input logic        usb_pkt_avail,
    input logic [15:0] usb_pkt_len,
    input logic        usb_space,
    input logic        in_overrun,
    input logic [1:0]  buf_full,
    input logic        idx_hit
);
    // Status read shows the two fill flags and zero reserved bits.
    p_status_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_sel == 3'd3 && idx_hit) |-> (fw_rdata[15:2] == 14'd0 && fw_rdata[1:0] == buf_full));

    // A write into a full pair raises the refusal flag.
    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && fw_wr && fw_sel == 3'd1 && idx_hit && buf_full == 2'b11 && !bus_rst)
        |=> in_overrun);

    // A refused write leaves both buffers full.
    p_refuse_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && fw_wr && fw_sel == 3'd1 && idx_hit && buf_full == 2'b11 &&
         !bus_rst && !usb_pkt_done) |=> buf_full == 2'b11);

    // The refusal flag holds until a bus reset.
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_overrun && !bus_rst) |=> in_overrun);

    // Bus reset empties everything.
    p_bus_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (buf_full == 2'b00 && !in_overrun && !usb_pkt_avail));

    // The advertised IN packet never exceeds the maximum size.
    p_avail_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_pkt_avail |-> (cfg_dir_in && usb_pkt_len <= 16'(MAX_PKT)));

    // OUT space is offered only while a buffer is free.
    p_space_r12: assert property (@(posedge clk) disable iff (!rst_n)
        usb_space |-> (!cfg_dir_in && buf_full != 2'b11));

    // An accepted OUT packet fills exactly one more buffer.
    p_out_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && usb_space && usb_pkt_done && !bus_rst && !fw_rd)
        |=> $countones(buf_full) == $countones($past(buf_full)) + 1);
endmodule

bind ep_dbuf ep_dbuf_chk #(.MAX_PKT(MAX_PKT)) u_ep_dbuf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .cfg_dir_in   (cfg_dir_in),
    .fw_wr        (fw_wr),
    .fw_rd        (fw_rd),
    .fw_sel       (fw_sel),
    .fw_rdata     (fw_rdata),
    .usb_pkt_done (usb_pkt_done),
    .usb_pkt_avail(usb_pkt_avail),
    .usb_pkt_len  (usb_pkt_len),
    .usb_space    (usb_space),
    .in_overrun   (in_overrun),
    .buf_full     (buf_full),
    .idx_hit      (idx_hit)
);

// File: tb/ep_dbuf_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected observations, and a monitor at
// the falling edge pops each one and compares it with the design output.
module ep_dbuf_bench;
    localparam int MAX_PKT = 64;
    localparam logic [2:0] S_IDX = 3'd0, S_DATA = 3'd1, S_LEN = 3'd2,
                           S_STAT = 3'd3, S_CTRL = 3'd4;
    localparam int K_FW = 0, K_USB = 1, K_LEN = 2, K_AVAIL = 3, K_OVR = 4, K_SPACE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, bus_rst = 1'b0, cfg_dir_in = 1'b1;
    logic        fw_wr = 1'b0, fw_rd = 1'b0;
    logic [2:0]  fw_sel = '0;
    logic [15:0] fw_wdata = '0;
    logic [15:0] fw_rdata;
    logic        usb_byte_wr = 1'b0, usb_byte_rd = 1'b0, usb_pkt_done = 1'b0;
    logic [7:0]  usb_wdata = '0;
    logic [7:0]  usb_rdata;
    logic        usb_pkt_avail, usb_space, in_overrun;
    logic [15:0] usb_pkt_len;

    typedef struct {
        int          kind;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    logic sample_req = 1'b0;
    int   checks = 0, failures = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ep_dbuf #(.MAX_PKT(MAX_PKT), .EP_ID(1), .IDX_W(4)) u_ep_dbuf (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cfg_dir_in(cfg_dir_in),
        .fw_wr(fw_wr), .fw_rd(fw_rd), .fw_sel(fw_sel), .fw_wdata(fw_wdata),
        .fw_rdata(fw_rdata), .usb_byte_wr(usb_byte_wr), .usb_wdata(usb_wdata),
        .usb_byte_rd(usb_byte_rd), .usb_rdata(usb_rdata), .usb_pkt_done(usb_pkt_done),
        .usb_pkt_avail(usb_pkt_avail), .usb_pkt_len(usb_pkt_len),
        .usb_space(usb_space), .in_overrun(in_overrun)
    );

    // Monitor: compare each queued expectation with the live output.
    always @(negedge clk) begin
        if (sample_req && exp_q.size() > 0) begin
            exp_t e;
            logic [15:0] act;
            e = exp_q.pop_front();
            case (e.kind)
                K_FW:    act = fw_rdata;
                K_USB:   act = {8'd0, usb_rdata};
                K_LEN:   act = usb_pkt_len;
                K_AVAIL: act = {15'd0, usb_pkt_avail};
                K_OVR:   act = {15'd0, in_overrun};
                default: act = {15'd0, usb_space};
            endcase
            checks++;
            if (act !== e.val) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.val);
            end
        end
    end

    function automatic logic [7:0] pat_a(int i); return 8'h10 + 8'(i); endfunction
    function automatic logic [7:0] pat_b(int i); return 8'hA0 + 8'(i); endfunction
    function automatic logic [7:0] pat_e(int i); return 8'h80 + 8'(i); endfunction

    task automatic push(int kind, logic [15:0] val, string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        exp_q.push_back(e);
        sample_req = 1'b1;
    endtask

    task automatic end_cycle();
        @(posedge clk); #1;
        fw_wr = 0; fw_rd = 0; usb_byte_wr = 0; usb_byte_rd = 0;
        usb_pkt_done = 0; bus_rst = 0; sample_req = 0;
    endtask

    task automatic fw_write(logic [2:0] sel, logic [15:0] d);
        @(posedge clk); #1; fw_sel = sel; fw_wdata = d; fw_wr = 1; end_cycle();
    endtask

    task automatic fw_read(logic [2:0] sel, logic [15:0] exp, string req);
        @(posedge clk); #1; fw_sel = sel; fw_rd = 1; push(K_FW, exp, req); end_cycle();
    endtask

    task automatic observe(int kind, logic [15:0] exp, string req);
        @(posedge clk); #1; push(kind, exp, req); end_cycle();
    endtask

    task automatic usb_read(logic [7:0] exp, string req);
        @(posedge clk); #1; usb_byte_rd = 1; push(K_USB, {8'd0, exp}, req); end_cycle();
    endtask

    task automatic usb_write(logic [7:0] d);
        @(posedge clk); #1; usb_wdata = d; usb_byte_wr = 1; end_cycle();
    endtask

    task automatic usb_done();
        @(posedge clk); #1; usb_pkt_done = 1; end_cycle();
    endtask

    task automatic do_bus_reset(logic dir_in);
        @(posedge clk); #1; bus_rst = 1; cfg_dir_in = dir_in; end_cycle();
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: the whole stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        fw_write(S_IDX, 16'd1);
        // R1 reset state
        fw_read(S_STAT, 16'd0, "R1");
        fw_read(S_LEN, 16'd0, "R1");
        observe(K_OVR, 16'd0, "R1");
        observe(K_AVAIL, 16'd0, "R1");

        // R2 index gating
        fw_write(S_IDX, 16'd0);
        fw_write(S_LEN, 16'd5);
        fw_read(S_LEN, 16'd0, "R2");
        fw_write(S_IDX, 16'd2);
        fw_write(S_CTRL, 16'd1);
        fw_write(S_IDX, 16'd1);
        fw_read(S_LEN, 16'd0, "R2");
        fw_read(S_STAT, 16'd0, "R2");

        // R3 full-size packet into buffer 0
        for (int k = 0; k < MAX_PKT / 2; k++)
            fw_write(S_DATA, {pat_a(2*k+1), pat_a(2*k)});
        fw_read(S_STAT, 16'd1, "R3");
        observe(K_AVAIL, 16'd1, "R9");
        observe(K_LEN, 16'(MAX_PKT), "R9");

        // R4 short packet of 7 into buffer 1
        fw_write(S_LEN, 16'd7);
        fw_read(S_LEN, 16'd7, "R4");
        for (int k = 0; k < 3; k++)
            fw_write(S_DATA, {pat_b(2*k+1), pat_b(2*k)});
        fw_read(S_STAT, 16'd1, "R4");
        fw_write(S_DATA, {8'hEE, pat_b(6)});
        fw_read(S_STAT, 16'd3, "R4");
        fw_read(S_STAT, 16'd3, "R7");

        // R8 refusal when both full
        fw_write(S_DATA, 16'h5555);
        observe(K_OVR, 16'd1, "R8");
        fw_read(S_STAT, 16'd3, "R8");

        // R9 drain buffer 0
        for (int i = 0; i < MAX_PKT; i++) usb_read(pat_a(i), "R9");
        usb_done();
        fw_read(S_STAT, 16'd2, "R9");
        observe(K_LEN, 16'd7, "R9");

        // R5 odd tail, low lane, nothing past the end
        for (int i = 0; i < 7; i++) usb_read(pat_b(i), "R5");
        usb_read(8'd0, "R5");
        usb_done();
        fw_read(S_STAT, 16'd0, "R7");

        // R6 manual validate, then a zero-length packet
        fw_write(S_LEN, 16'd0);
        fw_write(S_DATA, 16'h2221);
        fw_write(S_DATA, 16'h2423);
        fw_read(S_STAT, 16'd0, "R6");
        fw_write(S_CTRL, 16'd1);
        fw_read(S_STAT, 16'd1, "R6");
        observe(K_LEN, 16'd4, "R6");
        usb_read(8'h21, "R6"); usb_read(8'h22, "R6");
        usb_read(8'h23, "R6"); usb_read(8'h24, "R6");
        usb_done();
        fw_write(S_CTRL, 16'd1);
        fw_read(S_STAT, 16'd2, "R6");
        observe(K_AVAIL, 16'd1, "R6");
        observe(K_LEN, 16'd0, "R6");
        usb_done();
        fw_read(S_STAT, 16'd0, "R6");

        // R13 bus reset while IN packet partly filled; switch to OUT
        fw_write(S_DATA, 16'h3131);
        observe(K_OVR, 16'd1, "R8");
        do_bus_reset(1'b0);
        fw_read(S_STAT, 16'd0, "R13");
        observe(K_OVR, 16'd0, "R13");
        fw_read(S_LEN, 16'd0, "R13");

        // R10 OUT packets of 5 and MAX_PKT bytes
        observe(K_SPACE, 16'd1, "R12");
        for (int i = 0; i < 5; i++) usb_write(8'h30 + 8'(i));
        usb_done();
        fw_read(S_STAT, 16'd1, "R10");
        fw_read(S_LEN, 16'd5, "R10");
        for (int i = 0; i < MAX_PKT; i++) usb_write(pat_e(i));
        usb_done();
        fw_read(S_STAT, 16'd3, "R10");
        observe(K_SPACE, 16'd0, "R12");

        // R12 bytes and done while full are ignored
        for (int i = 0; i < 3; i++) usb_write(8'hFF);
        usb_done();
        fw_read(S_STAT, 16'd3, "R12");
        fw_read(S_LEN, 16'd5, "R12");

        // R11 firmware drains both packets
        fw_read(S_DATA, 16'h3130, "R11");
        fw_read(S_DATA, 16'h3332, "R11");
        fw_read(S_DATA, 16'h0034, "R11");
        fw_read(S_STAT, 16'd2, "R11");
        fw_read(S_LEN, 16'(MAX_PKT), "R11");
        for (int k = 0; k < MAX_PKT / 2; k++)
            fw_read(S_DATA, {pat_e(2*k+1), pat_e(2*k)}, "R11");
        fw_read(S_STAT, 16'd0, "R11");

        // R12 the refused bytes left no trace in the next packet
        usb_write(8'h41); usb_write(8'h42);
        usb_done();
        fw_read(S_LEN, 16'd2, "R12");
        fw_read(S_DATA, 16'h4241, "R12");

        // R13 bus reset with an OUT packet pending
        for (int i = 0; i < 3; i++) usb_write(8'h50 + 8'(i));
        usb_done();
        fw_read(S_STAT, 16'd2, "R13");
        do_bus_reset(1'b0);
        fw_read(S_STAT, 16'd0, "R13");
        fw_read(S_LEN, 16'd0, "R13");
        observe(K_SPACE, 16'd1, "R13");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule